// File: doc/BRIEF.md
# Hot-plug slot control and status

This block keeps the slot-level registers of a downstream port that can accept and release cards while running: a read-only capability word, a control field (event enables, the hot-plug interrupt enable, two indicator codes and a lock command) and a status field (three sticky events, card presence and lock state). Software reaches them through a 32-bit configuration port with byte enables. Hardware reports card insertion, card removal and attention-button presses as single-cycle input pulses.

Each sticky event is set by its source and cleared by writing one to it. Any write that touches either of the two control bytes counts as one command and sets the command-completed event. Writing one to the lock command flips the lock state; the command bit itself always reads back as zero. While the lock is engaged, insertion and removal requests are refused and reported on an error pulse. A notify condition (interrupt enable AND any event that is both pending and enabled) drives a legacy level interrupt when message interrupts are off, or one message request, tagged with the supplied vector number, each time the condition turns true when they are on. Masking is not part of the condition's history: an event pending while disabled is reported as soon as it is enabled.

Word map (dword address): `CAP_WORD` (default 0) holds the capability; `SLOT_WORD` (default 1) holds control in bits [15:0] and status in bits [31:16].

Top module: `hp_slot_top`

## Requirements
- R1: After reset the slot word reads 0x0000_00F0: event enables and interrupt enable are 0, both indicator codes (control bits [5:4] attention, [7:6] power) are 2'b11 meaning off, all status bits are 0; `intx_o`, `msi_req_o` and `plug_err_o` are 0.
- R2: `cfg_rdata` is combinational: with `cfg_rd` high it shows the addressed word in the same cycle; the capability word reads {SLOT_NUM[12:0] at [31:19], zeros, 5'b11111 at [4:0]}; any other address or `cfg_rd` low reads 0.
- R3: Control byte 0 (bits [2:0] event enables for button/presence-change/command-completed, bit 3 interrupt enable, [7:4] indicators) is written only when `cfg_be[0]` is set; control bits [15:8] always read 0 and byte 1 never alters byte 0.
- R4: A write to `SLOT_WORD` with `cfg_be[0]` or `cfg_be[1]` set is one command and sets status bit 18 (command completed) in the next cycle, even if no value changes and even if the same write clears that bit; a write touching only bytes 2 or 3 sets nothing.
- R5: A command with `cfg_be[1]` set and data bit 8 set flips the lock state in status bit 20.
- R6: An accepted insertion sets presence state (bit 19) and presence-changed (bit 17); an accepted removal clears presence state and sets presence-changed.
- R7: While the lock state is 1, an insertion or removal leaves the status unchanged and pulses `plug_err_o` for exactly one cycle, one cycle after the request.
- R8: A button press sets status bit 16 (button pressed).
- R9: With `cfg_be[2]` set, data bits 16..18 clear the matching event bits; presence state and lock state ignore writes.
- R10: The notify condition is interrupt-enable AND (events AND enables) nonzero; with `msi_en` low `intx_o` equals it one cycle after the status or control change.
- R11: With `msi_en` high, `msi_req_o` pulses for one cycle, with `msi_vec_o` = `msg_num`, only when the condition turns from false to true; raising an event that is already pending requests nothing.
- R12: An event that is pending while its enable or the interrupt enable is off is signalled once both are turned on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Dword address |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, same cycle as `cfg_rd` |
| plug_insert | input | 1 | Card insertion pulse |
| plug_remove | input | 1 | Card removal pulse |
| button_press | input | 1 | Attention button pulse |
| msi_en | input | 1 | Message interrupts enabled |
| msg_num | input | VEC_W | Interrupt message number |
| intx_o | output | 1 | Legacy level interrupt |
| msi_req_o | output | 1 | One-cycle message interrupt request |
| msi_vec_o | output | VEC_W | Message number of the request |
| plug_err_o | output | 1 | One-cycle refusal pulse |

## Verification
Register effects of a write or an event pulse appear one clock edge after the strobe, so the bench drives on the falling edge and reads the slot word on the following falling edge, when the combinational read path already shows the new value. The interrupt outputs sit behind one more register, so level checks wait one extra cycle, and message requests are counted on every falling edge across a window of several cycles so that a missing or duplicated pulse shows in the count. The refusal pulse is sampled at the first falling edge after the request and again one cycle later to prove it is a single cycle wide.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

  localparam int NUM_EV = 3;
  localparam logic [NUM_EV-1:0] EV_SUPPORTED = 3'b111;
  localparam logic [1:0] IND_OFF = 2'b11;

  localparam int CTL_LOCK_BIT = 8;
  localparam int STS_LSB = 16;

  localparam int EV_BUTTON = 0;
  localparam int EV_PRES   = 1;
  localparam int EV_CMD    = 2;

  typedef struct packed {
    logic [1:0]        pwr_ind;
    logic [1:0]        attn_ind;
    logic              hpie;
    logic [NUM_EV-1:0] ev_en;
  } slot_ctl_t;

  typedef struct packed {
    logic              lock;
    logic              pds;
    logic [NUM_EV-1:0] ev;
  } slot_sts_t;

endpackage

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  logic [1:0] be,
  input  logic [8:0] wdata,
  output slot_ctl_t ctl,
  output logic      cmd,
  output logic      lock_toggle
);

  slot_ctl_t ctl_q, ctl_d;
  logic      ctl_en;

  always_comb begin
    ctl_en      = wr_hit & be[0];
    ctl_d       = slot_ctl_t'(wdata[7:0]);
    cmd         = wr_hit & (|be);
    lock_toggle = wr_hit & be[1] & wdata[CTL_LOCK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.pwr_ind  <= IND_OFF;
      ctl_q.attn_ind <= IND_OFF;
      ctl_q.hpie     <= 1'b0;
      ctl_q.ev_en    <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl = ctl_q;

  // R3: control holds its value when no write reaches byte 0
  p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && be[0]) |=> $stable(ctl_q));

endmodule

// File: rtl/hp_slot_status.sv
module hp_slot_status
  import hp_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_insert,
  input  logic              ev_remove,
  input  logic              ev_button,
  input  logic              cmd,
  input  logic              lock_toggle,
  input  logic              clr_wr,
  input  logic [NUM_EV-1:0] clr_bits,
  output slot_sts_t         sts,
  output logic              plug_err
);

  slot_sts_t         sts_q;
  logic [NUM_EV-1:0] ev_d, set_vec, clr_vec;
  logic              pds_d, lock_d, pds_en;
  logic              plug_req, accept, refused;
  logic              err_q;

  always_comb begin
    plug_req = ev_insert | ev_remove;
    refused  = plug_req & sts_q.lock;
    accept   = plug_req & ~sts_q.lock;
    pds_en   = accept;
    pds_d    = ev_insert;
    lock_d   = sts_q.lock ^ lock_toggle;
    set_vec            = '0;
    set_vec[EV_BUTTON] = ev_button;
    set_vec[EV_PRES]   = accept;
    set_vec[EV_CMD]    = cmd;
    clr_vec  = clr_wr ? (clr_bits & EV_SUPPORTED) : '0;
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    always_comb ev_d[i] = set_vec[i] | (sts_q.ev[i] & ~clr_vec[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q.ev[i] <= 1'b0;
      else        sts_q.ev[i] <= ev_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q.pds  <= 1'b0;
      sts_q.lock <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (pds_en) sts_q.pds <= pds_d;
      if (lock_toggle) sts_q.lock <= lock_d;
      err_q <= refused;
    end
  end

  assign sts      = sts_q;
  assign plug_err = err_q;

  // R4: a command always leaves command-completed set
  p_cc_after_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> sts_q.ev[EV_CMD]);

  // R5: the lock command flips the lock state
  p_lock_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_toggle |=> (sts_q.lock != $past(sts_q.lock)));

  // R6: accepted insertion shows presence
  p_pds_insert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_insert && !sts_q.lock) |=> sts_q.pds);

  // R7: a refused request keeps presence and raises the error
  p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (plug_req && sts_q.lock) |=> ($stable(sts_q.pds) && err_q));

endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_ctl_t        ctl,
  input  slot_sts_t        sts,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] msg_num,
  output logic             intx,
  output logic             msi_req,
  output logic [VEC_W-1:0] msi_vec
);

  logic             notify_c, notify_q, rise;
  logic             msi_q;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    notify_c = ctl.hpie & (|(sts.ev & ctl.ev_en & EV_SUPPORTED));
    rise     = notify_c & ~notify_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_q <= 1'b0;
      msi_q    <= 1'b0;
      vec_q    <= '0;
    end else begin
      notify_q <= notify_c;
      msi_q    <= rise & msi_en;
      if (rise & msi_en) vec_q <= msg_num;
    end
  end

  assign intx    = notify_q & ~msi_en;
  assign msi_req = msi_q;
  assign msi_vec = vec_q;

  // R11: a request lasts one cycle
  p_msi_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msi_q |=> !msi_q);

  // R11: no request unless message interrupts were enabled
  p_msi_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msi_q |-> $past(msi_en));

endmodule

// File: rtl/hp_slot_top.sv
module hp_slot_top
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CAP_WORD  = 0,
  parameter int SLOT_WORD = 1,
  parameter int SLOT_NUM  = 5,
  parameter int VEC_W     = 5
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              plug_insert,
  input  logic              plug_remove,
  input  logic              button_press,
  input  logic              msi_en,
  input  logic [VEC_W-1:0]  msg_num,
  output logic              intx_o,
  output logic              msi_req_o,
  output logic [VEC_W-1:0]  msi_vec_o,
  output logic              plug_err_o
);

  localparam logic [ADDR_W-1:0] CAP_A  = ADDR_W'(CAP_WORD);
  localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_WORD);
  localparam logic [12:0]       SLOT_BITS = 13'(SLOT_NUM);
  localparam logic [31:0]       CAP_VAL = {SLOT_BITS, 14'b0, 5'b11111};

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  slot_ctl_t ctl;
  slot_sts_t sts;
  logic      wr_hit, cmd, lock_toggle, clr_wr;
  logic      unused_inputs;

  assign wr_hit        = cfg_wr & (cfg_addr == SLOT_A);
  assign clr_wr        = wr_hit & cfg_be[2];
  assign unused_inputs = ^{cfg_wdata[31:19], cfg_wdata[15:9], cfg_be[3]};

  hp_slot_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit      (wr_hit),
    .be          (cfg_be[1:0]),
    .wdata       (cfg_wdata[8:0]),
    .ctl         (ctl),
    .cmd         (cmd),
    .lock_toggle (lock_toggle)
  );

  hp_slot_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_insert   (plug_insert),
    .ev_remove   (plug_remove),
    .ev_button   (button_press),
    .cmd         (cmd),
    .lock_toggle (lock_toggle),
    .clr_wr      (clr_wr),
    .clr_bits    (cfg_wdata[STS_LSB +: NUM_EV]),
    .sts         (sts),
    .plug_err    (plug_err_o)
  );

  hp_slot_notify #(.VEC_W(VEC_W)) u_notify (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .sts     (sts),
    .msi_en  (msi_en),
    .msg_num (msg_num),
    .intx    (intx_o),
    .msi_req (msi_req_o),
    .msi_vec (msi_vec_o)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_rd) begin
      if (cfg_addr == CAP_A) begin
        cfg_rdata = CAP_VAL;
      end else if (cfg_addr == SLOT_A) begin
        cfg_rdata[7:0]                 = ctl;
        cfg_rdata[STS_LSB +: NUM_EV+2] = sts;
      end
    end
  end

endmodule

// File: tb/sim_hp_slot_top.sv
`timescale 1ns/1ps
module sim_hp_slot_top;

  localparam int SLOT_NUM = 5;
  localparam logic [3:0] SLOT = 4'd1;
  localparam logic [3:0] CAPW = 4'd0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        plug_insert = 1'b0, plug_remove = 1'b0, button_press = 1'b0;
  logic        msi_en = 1'b0;
  logic [4:0]  msg_num = 5'h13;
  logic        intx_o, msi_req_o, plug_err_o;
  logic [4:0]  msi_vec_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int msi_cnt = 0;
  logic [4:0] last_vec = '0;
  logic pds_m = 1'b0;

  always #4 clk = ~clk;

  hp_slot_top u0 (
    .clk(clk), .rst_ni(rst_ni), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .plug_insert(plug_insert),
    .plug_remove(plug_remove), .button_press(button_press),
    .msi_en(msi_en), .msg_num(msg_num), .intx_o(intx_o),
    .msi_req_o(msi_req_o), .msi_vec_o(msi_vec_o), .plug_err_o(plug_err_o)
  );

  always @(negedge clk) begin
    if (msi_req_o) begin
      msi_cnt++;
      last_vec = msi_vec_o;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected below 50000", cyc);
      summary();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_exp(input logic lock, input logic pds,
                                           input logic [2:0] ev, input logic [7:0] ctl);
    return {11'b0, lock, pds, ev, 8'b0, ctl};
  endfunction

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = SLOT; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    cfg_rd = 1'b1; cfg_addr = a;
    #1;
    v = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  // kind: 0 button, 1 insert, 2 remove; returns error pulse seen after the request
  task automatic pulse(input int kind, output logic err);
    @(negedge clk);
    button_press = (kind == 0);
    plug_insert  = (kind == 1);
    plug_remove  = (kind == 2);
    @(negedge clk);
    err = plug_err_o;
    button_press = 1'b0; plug_insert = 1'b0; plug_remove = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    logic err;
    int c0;

    idle(3);
    rst_ni = 1'b1;
    idle(4);

    // R1 reset state
    rd(SLOT, v);
    check("R1 slot word after reset", v, 32'h0000_00F0);
    check("R1 intx after reset", {31'b0, intx_o}, 32'd0);
    check("R1 msi after reset", {31'b0, msi_req_o}, 32'd0);
    check("R1 err after reset", {31'b0, plug_err_o}, 32'd0);
    // R2 capability and idle read
    rd(CAPW, v);
    check("R2 capability word", v, {13'(SLOT_NUM), 14'b0, 5'b11111});
    #1;
    check("R2 read without strobe", cfg_rdata, 32'd0);
    rd(4'd7, v);
    check("R2 unmapped word", v, 32'd0);

    // R3 byte lanes, R4 command on byte 0
    wr(4'b0001, 32'h0000_FE2A);
    rd(SLOT, v);
    check("R3 byte0 write", v, slot_exp(0, 0, 3'b100, 8'h2A));
    wr(4'b0100, 32'h00FF_0000);
    rd(SLOT, v);
    check("R9 clear all events", v, slot_exp(0, 0, 3'b000, 8'h2A));
    wr(4'b0010, 32'h0000_FE00);
    rd(SLOT, v);
    check("R3 byte1 reserved reads zero, R4 command", v, slot_exp(0, 0, 3'b100, 8'h2A));
    wr(4'b0100, 32'h0004_0000);
    wr(4'b1000, 32'hFFFF_FFFF);
    rd(SLOT, v);
    check("R4 status-only write no command", v, slot_exp(0, 0, 3'b000, 8'h2A));
    wr(4'b0111, 32'h0007_002A);
    rd(SLOT, v);
    check("R4 command wins over same-write clear", v, slot_exp(0, 0, 3'b100, 8'h2A));

    // R10 R12 R8 R6 sweep over enables and pending events
    for (int c = 0; c < 16; c++) begin
      for (int e = 0; e < 8; e++) begin
        logic [7:0] cv;
        logic [2:0] ev;
        cv = {4'hF, 4'(c)};
        ev = 3'(e);
        wr(4'b0001, {24'b0, cv});
        wr(4'b0100, 32'h0007_0000);
        if (ev[0]) pulse(0, err);
        if (ev[1]) begin
          pulse(1, err);
          pds_m = 1'b1;
        end
        if (ev[2]) wr(4'b0001, {24'b0, cv});
        idle(1);
        check("R10 intx level from sweep", {31'b0, intx_o},
              {31'b0, cv[3] & |(ev & cv[2:0])});
        rd(SLOT, v);
        check("R8 R6 R4 status in sweep", v, slot_exp(0, pds_m, ev, cv));
      end
    end

    // R12 enable after pending, legacy path
    wr(4'b0001, 32'h0000_00F0);
    wr(4'b0100, 32'h0007_0000);
    pulse(0, err);
    idle(1);
    check("R12 pending while disabled", {31'b0, intx_o}, 32'd0);
    wr(4'b0001, 32'h0000_00F9);
    idle(1);
    check("R12 delivered on enable", {31'b0, intx_o}, 32'd1);
    wr(4'b0100, 32'h0001_0000);
    idle(1);
    check("R10 intx drops after clear", {31'b0, intx_o}, 32'd0);

    // R5 lock, R7 refusal, R9 read-only bits
    wr(4'b0100, 32'h0007_0000);
    wr(4'b0010, 32'h0000_0100);
    rd(SLOT, v);
    check("R5 lock engaged", v, slot_exp(1, pds_m, 3'b100, 8'hF9));
    pulse(1, err);
    check("R7 insert refused err", {31'b0, err}, 32'd1);
    idle(1);
    check("R7 err single cycle", {31'b0, plug_err_o}, 32'd0);
    pulse(2, err);
    check("R7 remove refused err", {31'b0, err}, 32'd1);
    rd(SLOT, v);
    check("R7 status unchanged", v, slot_exp(1, pds_m, 3'b100, 8'hF9));
    wr(4'b1100, 32'hFFFF_0000);
    rd(SLOT, v);
    check("R9 presence and lock ignore writes", v, slot_exp(1, pds_m, 3'b000, 8'hF9));
    wr(4'b0010, 32'h0000_0100);
    rd(SLOT, v);
    check("R5 lock released", v, slot_exp(0, pds_m, 3'b100, 8'hF9));
    wr(4'b0100, 32'h0007_0000);
    pulse(2, err);
    check("R6 remove accepted no err", {31'b0, err}, 32'd0);
    rd(SLOT, v);
    check("R6 removal clears presence", v, slot_exp(0, 0, 3'b010, 8'hF9));
    wr(4'b0100, 32'h0002_0000);
    pulse(1, err);
    rd(SLOT, v);
    check("R6 insertion sets presence", v, slot_exp(0, 1, 3'b010, 8'hF9));

    // R11 message path
    msi_en = 1'b1;
    wr(4'b0100, 32'h0007_0000);
    idle(2);
    c0 = msi_cnt;
    pulse(0, err);
    idle(3);
    check("R11 one request on rise", 32'(msi_cnt - c0), 32'd1);
    check("R11 vector", {27'b0, last_vec}, {27'b0, msg_num});
    check("R11 intx quiet with msi", {31'b0, intx_o}, 32'd0);
    pulse(0, err);
    idle(3);
    check("R11 no request for pending event", 32'(msi_cnt - c0), 32'd1);
    wr(4'b0100, 32'h0001_0000);
    msg_num = 5'h07;
    idle(1);
    pulse(0, err);
    idle(3);
    check("R11 request after clear", 32'(msi_cnt - c0), 32'd2);
    check("R11 new vector", {27'b0, last_vec}, 32'h0000_0007);

    // R12 message path
    wr(4'b0001, 32'h0000_00F1);
    wr(4'b0100, 32'h0007_0000);
    idle(2);
    c0 = msi_cnt;
    pulse(0, err);
    idle(3);
    check("R12 no request while masked", 32'(msi_cnt - c0), 32'd0);
    wr(4'b0001, 32'h0000_00F9);
    idle(3);
    check("R12 request on unmask", 32'(msi_cnt - c0), 32'd1);

    summary();
  end

endmodule